// File: doc/BRIEF.md
# Single-cycle RV32I control decoder

This block is the control unit of a processor that runs one instruction per clock cycle. It is purely combinational. It takes the 32-bit instruction word and the two flags from the register comparator, equal and less-than. From these it sets every control point of the datapath: the immediate format, the register write enable, the comparator's signedness, the two ALU operand sources, the ALU operation, the data memory direction, the write-back source and the next-PC source.

It handles the integer register-register group, the register-immediate arithmetic group, loads, stores, the six conditional branches and both jumps. The branch decision is made inside the decoder. The live comparator flags are combined with funct3, so the next-PC select already says taken or not taken. The datapath only has to steer the ALU result or PC+4 into the PC.

The decoder is split into two parts. An opcode classifier produces a one-hot struct of instruction-class strobes. A steering stage turns those strobes, funct3, instruction bit 30 and the flags into the output fields.

Top module: `rvd_decoder`

## Requirements

Encodings used throughout:
- Opcodes (instWord[6:0]): register-register 0110011, register-immediate 0010011, load 0000011, store 0100011, branch 1100011, JAL 1101111, JALR 1100111.
- immSel: I=0, S=1, B=2, U=3, J=4.
- aluSel: ADD=0, SUB=1, SLL=2, SLT=3, SLTU=4, XOR=5, SRL=6, SRA=7, OR=8, AND=9.
- wbSel: memory data=0, ALU=1, PC+4=2.
- memWrite: 1 = write, 0 = read.
- aSelPc: 1 = PC, 0 = rs1.
- bSelImm: 1 = immediate, 0 = rs2.
- pcSelAlu: 1 = ALU result, 0 = PC+4.
- funct3 is instWord[14:12].

- R1: Register-register opcode gives regWen=1, aSelPc=0, bSelImm=0, wbSel=1, memWrite=0, pcSelAlu=0 and immSel=0. The ALU operation follows funct3 as follows:
  - 000: ADD, or SUB when instWord[30]=1.
  - 001: SLL. 010: SLT. 011: SLTU. 100: XOR.
  - 101: SRL, or SRA when instWord[30]=1.
  - 110: OR. 111: AND.
- R2: Register-immediate opcode gives immSel=0, bSelImm=1, aSelPc=0, regWen=1, wbSel=1, memWrite=0 and pcSelAlu=0. The ALU operation uses the funct3 map of R1, with two differences: funct3 000 is always ADD whatever instWord[30] is, and funct3 101 picks SRA over SRL from instWord[30].
- R3: Load opcode (any funct3) gives immSel=0, bSelImm=1, aSelPc=0, aluSel=ADD, memWrite=0, regWen=1, wbSel=0 and pcSelAlu=0.
- R4: Store opcode gives immSel=1, regWen=0, bSelImm=1, aSelPc=0, aluSel=ADD, memWrite=1 and pcSelAlu=0. wbSel is driven to 1.
- R5: Branch opcode gives immSel=2, aSelPc=1, bSelImm=1, aluSel=ADD, regWen=0, memWrite=0 and wbSel=1.
- R6: On a branch, pcSelAlu is set by funct3 and the flags:
  - 000: equal. 001: not equal.
  - 100 and 110: less-than.
  - 101 and 111: not less-than.
- R7: cmpUnsigned is 1 only for a branch with funct3 110 or 111, and 0 for every other instruction.
- R8: JALR opcode gives immSel=0, aSelPc=0, bSelImm=1, aluSel=ADD, regWen=1, wbSel=2, memWrite=0 and pcSelAlu=1.
- R9: JAL opcode gives immSel=4, aSelPc=1, bSelImm=1, aluSel=ADD, regWen=1, wbSel=2, memWrite=0 and pcSelAlu=1.
- R10: An opcode outside the seven above gives regWen=0, memWrite=0 and pcSelAlu=0, together with immSel=0, aSelPc=0, bSelImm=0, aluSel=ADD and wbSel=1. A branch whose funct3 is 010 or 011 is never taken.
- R11: For every opcode except branch, JAL and JALR, the flags have no effect on any output and pcSelAlu is 0.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| instWord | input | 32 | Instruction word being executed this cycle |
| cmpEq | input | 1 | Comparator flag: operands equal |
| cmpLt | input | 1 | Comparator flag: rs1 less than rs2 (signedness per cmpUnsigned) |
| immSel | output | 3 | Immediate format select |
| regWen | output | 1 | Register file write enable |
| cmpUnsigned | output | 1 | Request unsigned less-than comparison |
| aSelPc | output | 1 | ALU operand A source: 1 PC, 0 rs1 |
| bSelImm | output | 1 | ALU operand B source: 1 immediate, 0 rs2 |
| aluSel | output | 4 | ALU operation code |
| memWrite | output | 1 | Data memory direction: 1 write, 0 read |
| wbSel | output | 2 | Write-back source: 0 memory, 1 ALU, 2 PC+4 |
| pcSelAlu | output | 1 | Next PC source: 1 ALU result, 0 PC+4 |

## Verification

In a single cycle the decoder both chooses the comparator's signedness and consumes the comparator's flags to decide the branch. The unsigned branches are therefore driven with flag values that would give the opposite outcome under the other reading of funct3. Each result is judged on both cmpUnsigned and pcSelAlu together.

The flags are also raised during non-branch instructions, such as an immediate add or a store, and during the two reserved branch funct3 codes. In those cases the whole output word must be the same as if the flags had been low.

// File: rtl/rvd_pkg.sv
package rvd_pkg;

  localparam int INSN_W = 32;
  localparam int OPC_W  = 7;
  localparam int F3_W   = 3;
  localparam int ALU_W  = 4;

  localparam logic [OPC_W-1:0] OPC_REG    = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_IMM    = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;

  typedef enum logic [2:0] {
    IMM_I = 3'd0,
    IMM_S = 3'd1,
    IMM_B = 3'd2,
    IMM_U = 3'd3,
    IMM_J = 3'd4
  } immFmt_e;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_SLL  = 4'd2,
    ALU_SLT  = 4'd3,
    ALU_SLTU = 4'd4,
    ALU_XOR  = 4'd5,
    ALU_SRL  = 4'd6,
    ALU_SRA  = 4'd7,
    ALU_OR   = 4'd8,
    ALU_AND  = 4'd9
  } aluOp_e;

  typedef enum logic [1:0] {
    WB_MEM = 2'd0,
    WB_ALU = 2'd1,
    WB_PC4 = 2'd2
  } wbSrc_e;

  // One-hot instruction class strobes: classifier to steering stage
  typedef struct packed {
    logic regOp;
    logic immOp;
    logic load;
    logic store;
    logic branch;
    logic jal;
    logic jalr;
  } insnClass_t;

endpackage

// File: rtl/rvd_class.sv
module rvd_class
  import rvd_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output insnClass_t       cls
);

  always_comb begin
    cls = '0;
    unique case (opcode)
      OPC_REG:    cls.regOp  = 1'b1;
      OPC_IMM:    cls.immOp  = 1'b1;
      OPC_LOAD:   cls.load   = 1'b1;
      OPC_STORE:  cls.store  = 1'b1;
      OPC_BRANCH: cls.branch = 1'b1;
      OPC_JAL:    cls.jal    = 1'b1;
      OPC_JALR:   cls.jalr   = 1'b1;
      default:    cls        = '0;
    endcase
  end

endmodule

// File: rtl/rvd_alu_map.sv
module rvd_alu_map
  import rvd_pkg::*;
(
  input  logic [F3_W-1:0] funct3,
  input  logic            altBit,
  input  logic            allowSub,
  output aluOp_e          aluOp
);

  always_comb begin
    unique case (funct3)
      3'b000:  aluOp = (allowSub && altBit) ? ALU_SUB : ALU_ADD;
      3'b001:  aluOp = ALU_SLL;
      3'b010:  aluOp = ALU_SLT;
      3'b011:  aluOp = ALU_SLTU;
      3'b100:  aluOp = ALU_XOR;
      3'b101:  aluOp = altBit ? ALU_SRA : ALU_SRL;
      3'b110:  aluOp = ALU_OR;
      default: aluOp = ALU_AND;
    endcase
  end

endmodule

// File: rtl/rvd_branch_eval.sv
module rvd_branch_eval
  import rvd_pkg::*;
(
  input  logic [F3_W-1:0] funct3,
  input  logic            cmpEq,
  input  logic            cmpLt,
  output logic            taken,
  output logic            wantUnsigned
);

  // funct3[2] picks the less-than family, funct3[0] inverts the sense,
  // funct3[1] (within the less-than family) asks for unsigned comparison.
  always_comb begin
    unique case (funct3)
      3'b000:         taken = cmpEq;
      3'b001:         taken = !cmpEq;
      3'b100, 3'b110: taken = cmpLt;
      3'b101, 3'b111: taken = !cmpLt;
      default:        taken = 1'b0;
    endcase
    wantUnsigned = funct3[2] & funct3[1];
  end

endmodule

// File: rtl/rvd_steer.sv
module rvd_steer
  import rvd_pkg::*;
(
  input  insnClass_t      cls,
  input  logic [F3_W-1:0] funct3,
  input  logic            altBit,
  input  logic            cmpEq,
  input  logic            cmpLt,
  output logic [2:0]      immSel,
  output logic            regWen,
  output logic            cmpUnsigned,
  output logic            aSelPc,
  output logic            bSelImm,
  output logic [ALU_W-1:0] aluSel,
  output logic            memWrite,
  output logic [1:0]      wbSel,
  output logic            pcSelAlu
);

  aluOp_e mappedOp;
  logic   brTaken;
  logic   brUnsigned;

  rvd_alu_map u_aluMap (
    .funct3   (funct3),
    .altBit   (altBit),
    .allowSub (cls.regOp),
    .aluOp    (mappedOp)
  );

  rvd_branch_eval u_brEval (
    .funct3       (funct3),
    .cmpEq        (cmpEq),
    .cmpLt        (cmpLt),
    .taken        (brTaken),
    .wantUnsigned (brUnsigned)
  );

  always_comb begin
    // Safe default: no state is written and the PC simply advances
    immSel      = IMM_I;
    regWen      = 1'b0;
    cmpUnsigned = 1'b0;
    aSelPc      = 1'b0;
    bSelImm     = 1'b0;
    aluSel      = ALU_ADD;
    memWrite    = 1'b0;
    wbSel       = WB_ALU;
    pcSelAlu    = 1'b0;

    unique if (cls.regOp) begin
      regWen = 1'b1;
      aluSel = mappedOp;
    end else if (cls.immOp) begin
      regWen  = 1'b1;
      bSelImm = 1'b1;
      aluSel  = mappedOp;
    end else if (cls.load) begin
      regWen  = 1'b1;
      bSelImm = 1'b1;
      wbSel   = WB_MEM;
    end else if (cls.store) begin
      immSel   = IMM_S;
      bSelImm  = 1'b1;
      memWrite = 1'b1;
    end else if (cls.branch) begin
      immSel      = IMM_B;
      aSelPc      = 1'b1;
      bSelImm     = 1'b1;
      cmpUnsigned = brUnsigned;
      pcSelAlu    = brTaken;
    end else if (cls.jal) begin
      immSel   = IMM_J;
      aSelPc   = 1'b1;
      bSelImm  = 1'b1;
      regWen   = 1'b1;
      wbSel    = WB_PC4;
      pcSelAlu = 1'b1;
    end else if (cls.jalr) begin
      bSelImm  = 1'b1;
      regWen   = 1'b1;
      wbSel    = WB_PC4;
      pcSelAlu = 1'b1;
    end else begin
      pcSelAlu = 1'b0;
    end
  end

endmodule

// File: rtl/rvd_decoder.sv
module rvd_decoder
  import rvd_pkg::*;
(
  input  logic [INSN_W-1:0] instWord,
  input  logic              cmpEq,
  input  logic              cmpLt,
  output logic [2:0]        immSel,
  output logic              regWen,
  output logic              cmpUnsigned,
  output logic              aSelPc,
  output logic              bSelImm,
  output logic [ALU_W-1:0]  aluSel,
  output logic              memWrite,
  output logic [1:0]        wbSel,
  output logic              pcSelAlu
);

  insnClass_t clsStrobes;
  logic       unusedFields;

  // Register indices and immediate bits belong to the datapath
  assign unusedFields = ^{instWord[31], instWord[29:15], instWord[11:7]};

  rvd_class u_class (
    .opcode (instWord[OPC_W-1:0]),
    .cls    (clsStrobes)
  );

  rvd_steer u_steer (
    .cls         (clsStrobes),
    .funct3      (instWord[14:12]),
    .altBit      (instWord[30]),
    .cmpEq       (cmpEq),
    .cmpLt       (cmpLt),
    .immSel      (immSel),
    .regWen      (regWen),
    .cmpUnsigned (cmpUnsigned),
    .aSelPc      (aSelPc),
    .bSelImm     (bSelImm),
    .aluSel      (aluSel),
    .memWrite    (memWrite),
    .wbSel       (wbSel),
    .pcSelAlu    (pcSelAlu)
  );

endmodule

// File: rtl/rvd_decoder_chk.sv
module rvd_decoder_chk
  import rvd_pkg::*;
(
  input logic [INSN_W-1:0] instWord,
  input logic              cmpEq,
  input logic              regWen,
  input logic              cmpUnsigned,
  input logic              memWrite,
  input logic              pcSelAlu
);

  logic [OPC_W-1:0] opc;
  logic [F3_W-1:0]  f3;
  logic             knownOpc;
  logic             unusedChk;

  assign opc       = instWord[OPC_W-1:0];
  assign f3        = instWord[14:12];
  assign unusedChk = ^{instWord[31:15], instWord[11:7]};
  assign knownOpc  = (opc == OPC_REG) || (opc == OPC_IMM) || (opc == OPC_LOAD) ||
                     (opc == OPC_STORE) || (opc == OPC_BRANCH) ||
                     (opc == OPC_JAL) || (opc == OPC_JALR);

  always_comb begin
    // R10: an unknown opcode never writes state or redirects
    a_r10_unknown_safe: assert (knownOpc || (!regWen && !memWrite && !pcSelAlu));
    // R4: a memory write only comes from a store and never writes back
    a_r4_write_is_store: assert (!memWrite || (opc == OPC_STORE && !regWen));
    // R11: redirect only from branch or jump opcodes
    a_r11_redirect_source: assert (!pcSelAlu || opc == OPC_BRANCH ||
                                   opc == OPC_JAL || opc == OPC_JALR);
    // R7: unsigned compare only for the two unsigned branches
    a_r7_unsigned_branch_only: assert (!cmpUnsigned ||
                                       (opc == OPC_BRANCH && f3[2:1] == 2'b11));
    // R6: equality branch follows the equal flag
    a_r6_beq_follows_flag: assert (!(opc == OPC_BRANCH && f3 == 3'b000) ||
                                   (pcSelAlu == cmpEq));
  end

endmodule

bind rvd_decoder rvd_decoder_chk u_chk (
  .instWord    (instWord),
  .cmpEq       (cmpEq),
  .regWen      (regWen),
  .cmpUnsigned (cmpUnsigned),
  .memWrite    (memWrite),
  .pcSelAlu    (pcSelAlu)
);

// File: tb/rvd_decoder_bench.sv
`timescale 1ns/1ps
module rvd_decoder_bench;

  typedef struct packed {
    logic [2:0] imm;
    logic       rw;
    logic       un;
    logic       as;
    logic       bs;
    logic [3:0] alu;
    logic       mw;
    logic [1:0] wb;
    logic       pc;
  } outv_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instWord = 32'h0;
  logic        cmpEq = 1'b0;
  logic        cmpLt = 1'b0;
  logic [2:0]  immSel;
  logic        regWen, cmpUnsigned, aSelPc, bSelImm, memWrite, pcSelAlu;
  logic [3:0]  aluSel;
  logic [1:0]  wbSel;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  outv_t expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;  // 125 MHz

  rvd_decoder u_rvd_decoder (
    .instWord (instWord), .cmpEq (cmpEq), .cmpLt (cmpLt),
    .immSel (immSel), .regWen (regWen), .cmpUnsigned (cmpUnsigned),
    .aSelPc (aSelPc), .bSelImm (bSelImm), .aluSel (aluSel),
    .memWrite (memWrite), .wbSel (wbSel), .pcSelAlu (pcSelAlu)
  );

  // Expected outputs computed from the requirement text
  function automatic outv_t model(input logic [31:0] w, input logic eq, input logic lt);
    outv_t o;
    logic [2:0] f3;
    logic [3:0] amap;
    f3 = w[14:12];
    o = '{imm: 3'd0, rw: 1'b0, un: 1'b0, as: 1'b0, bs: 1'b0,
          alu: 4'd0, mw: 1'b0, wb: 2'd1, pc: 1'b0};
    case (f3)
      3'b000: amap = 4'd0;
      3'b001: amap = 4'd2;
      3'b010: amap = 4'd3;
      3'b011: amap = 4'd4;
      3'b100: amap = 4'd5;
      3'b101: amap = w[30] ? 4'd7 : 4'd6;
      3'b110: amap = 4'd8;
      default: amap = 4'd9;
    endcase
    case (w[6:0])
      7'b0110011: begin
        o.rw = 1; o.alu = (f3 == 3'b000 && w[30]) ? 4'd1 : amap;
      end
      7'b0010011: begin o.rw = 1; o.bs = 1; o.alu = amap; end
      7'b0000011: begin o.rw = 1; o.bs = 1; o.wb = 2'd0; end
      7'b0100011: begin o.imm = 3'd1; o.bs = 1; o.mw = 1; end
      7'b1100011: begin
        o.imm = 3'd2; o.as = 1; o.bs = 1;
        o.un = (f3 == 3'b110 || f3 == 3'b111);
        case (f3)
          3'b000: o.pc = eq;
          3'b001: o.pc = !eq;
          3'b100, 3'b110: o.pc = lt;
          3'b101, 3'b111: o.pc = !lt;
          default: o.pc = 0;
        endcase
      end
      7'b1101111: begin o.imm = 3'd4; o.as = 1; o.bs = 1; o.rw = 1; o.wb = 2'd2; o.pc = 1; end
      7'b1100111: begin o.bs = 1; o.rw = 1; o.wb = 2'd2; o.pc = 1; end
      default: ;
    endcase
    return o;
  endfunction

  task automatic drive(input logic [31:0] w, input logic eq, input logic lt, input string tag);
    @(posedge clk);
    #1;
    instWord = w; cmpEq = eq; cmpLt = lt;
    expQ.push_back(model(w, eq, lt));
    tagQ.push_back(tag);
  endtask

  // Monitor: compares at the falling edge, half a cycle after driving
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      outv_t e, a;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a = '{imm: immSel, rw: regWen, un: cmpUnsigned, as: aSelPc, bs: bSelImm,
            alu: aluSel, mw: memWrite, wb: wbSel, pc: pcSelAlu};
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s inst=%h actual=%h expected=%h", t, instWord, a, e);
      end
    end
  end

  localparam logic [6:0] OR_ = 7'b0110011, OI = 7'b0010011, OL = 7'b0000011,
                         OS = 7'b0100011, OB = 7'b1100011, OJ = 7'b1101111,
                         OJR = 7'b1100111;

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset state: all-zero word is an unknown opcode (R10)
    drive(32'h0, 1'b0, 1'b0, "R10");
    // R1 register-register
    drive({7'b0000000, 5'd2, 5'd1, 3'b000, 5'd3, OR_}, 0, 0, "R1");
    drive({7'b0100000, 5'd2, 5'd1, 3'b000, 5'd3, OR_}, 0, 0, "R1");
    for (int f = 1; f < 8; f++) begin
      drive({7'b0000000, 5'd4, 5'd5, 3'(f), 5'd6, OR_}, 0, 0, "R1");
    end
    drive({7'b0100000, 5'd4, 5'd5, 3'b101, 5'd6, OR_}, 0, 0, "R1");
    // R2 immediate arithmetic; bit30 set in an add immediate stays ADD
    drive({12'h400, 5'd1, 3'b000, 5'd15, OI}, 0, 0, "R2");
    drive({12'hFCE, 5'd1, 3'b000, 5'd15, OI}, 0, 0, "R2");
    drive({12'h405, 5'd1, 3'b101, 5'd15, OI}, 0, 0, "R2");
    drive({12'h005, 5'd1, 3'b101, 5'd15, OI}, 0, 0, "R2");
    drive({12'h003, 5'd1, 3'b111, 5'd15, OI}, 0, 0, "R2");
    // R3 loads
    drive({12'h008, 5'd2, 3'b010, 5'd14, OL}, 0, 0, "R3");
    drive({12'h001, 5'd2, 3'b100, 5'd14, OL}, 0, 0, "R3");
    // R4 store
    drive({7'b0000000, 5'd14, 5'd2, 3'b010, 5'd8, OS}, 0, 0, "R4");
    // R5/R6 branches
    drive({7'b0, 5'd2, 5'd1, 3'b000, 5'd8, OB}, 1, 0, "R5");
    drive({7'b0, 5'd2, 5'd1, 3'b000, 5'd8, OB}, 0, 1, "R6");
    drive({7'b0, 5'd2, 5'd1, 3'b001, 5'd8, OB}, 1, 0, "R6");
    drive({7'b0, 5'd2, 5'd1, 3'b001, 5'd8, OB}, 0, 0, "R6");
    drive({7'b0, 5'd2, 5'd1, 3'b100, 5'd8, OB}, 0, 1, "R6");
    drive({7'b0, 5'd2, 5'd1, 3'b100, 5'd8, OB}, 1, 0, "R6");
    drive({7'b0, 5'd2, 5'd1, 3'b101, 5'd8, OB}, 0, 1, "R6");
    drive({7'b0, 5'd2, 5'd1, 3'b101, 5'd8, OB}, 1, 0, "R6");
    // R7 unsigned branches; cmpUnsigned and decision in the same cycle
    drive({7'b0, 5'd2, 5'd1, 3'b110, 5'd8, OB}, 0, 1, "R7");
    drive({7'b0, 5'd2, 5'd1, 3'b110, 5'd8, OB}, 0, 0, "R7");
    drive({7'b0, 5'd2, 5'd1, 3'b111, 5'd8, OB}, 0, 0, "R7");
    drive({7'b0, 5'd2, 5'd1, 3'b111, 5'd8, OB}, 1, 1, "R7");
    // R10 reserved branch funct3 codes never taken
    drive({7'b0, 5'd2, 5'd1, 3'b010, 5'd8, OB}, 1, 1, "R10");
    drive({7'b0, 5'd2, 5'd1, 3'b011, 5'd8, OB}, 1, 1, "R10");
    // R8 / R9 jumps
    drive({12'h010, 5'd1, 3'b000, 5'd1, OJR}, 1, 1, "R8");
    drive({20'h00100, 5'd1, OJ}, 0, 0, "R9");
    // R10 unknown opcodes
    drive({20'h12345, 5'd3, 7'b0110111}, 1, 1, "R10");
    drive(32'hFFFF_FFFF, 1, 0, "R10");
    // R11 flags have no effect on non-branch instructions
    drive({12'h400, 5'd1, 3'b000, 5'd15, OI}, 1, 1, "R11");
    drive({7'b0, 5'd14, 5'd2, 3'b010, 5'd8, OS}, 1, 1, "R11");
    drive({7'b0100000, 5'd2, 5'd1, 3'b000, 5'd3, OR_}, 1, 1, "R11");
    drive({12'h008, 5'd2, 3'b010, 5'd14, OL}, 0, 1, "R11");
    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule